// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a single byte of power-control state on a simple special-function-register bus. One bit of that byte, the cold-start flag, records whether the most recent reset came from power being applied. A power-on reset sets the flag. A warm reset clears every other bit but leaves the flag as it was. Warm resets include a software-requested reset and a reset from the external pin.

Start-up code reads the byte and checks the flag. If the flag is set, the start was cold, and the code writes a 0 to the flag bit. A later warm reset then leaves the flag at 0, so the code can tell the two kinds of start apart. The other seven bits are plain read/write storage. Nothing inside the block acts on them.

Each raw reset input pulls its domain into reset asynchronously. The release of each domain is synchronised to the clock. The flag belongs to the cold domain. The other bits belong to the warm domain, which is held in reset by either of the two raw resets.

Top module: `rst_cause_reg`

## Requirements
- R1: After a power-on reset is released, a read at address 0x87 returns 0x10: the cold-start flag (bit 4) is 1 and every other bit is 0.
- R2: A warm reset leaves bit 4 unchanged and returns the other seven bits to 0. While the warm reset is held, writes have no effect.
- R3: A write to address 0x87 with bit 4 of the write data at 0 clears the cold-start flag.
- R4: A write with bit 4 of the write data at 1 leaves the flag unchanged. In particular, it does not set a flag that has been cleared.
- R5: A write to address 0x87 stores bits 7..5 and 3..0 of the write data, and they read back unchanged.
- R6: Reads are combinational. While the address is 0x87, the read data carries the whole byte in the same cycle and the select output is 1. At any other address the read data is 0x00 and the select output is 0.
- R7: Writes to any address other than 0x87 leave the byte unchanged.
- R8: A power-on reset wins over a warm reset and over a write in the same cycle. The byte comes out of reset as 0x10.
- R9: The release of each reset domain is synchronised to the clock. Writes take effect only once the warm domain has left reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_rst_n | input | 1 | Warm (software or pin) reset, active low, asynchronous assert |
| sfr_addr | input | ADDR_W (8) | Register bus address |
| sfr_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| sfr_wdata | input | DATA_W (8) | Write data |
| sfr_rdata | output | DATA_W (8) | Read data, combinational from the address |
| sfr_rsel | output | 1 | High while the address selects this register |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, the register at 0x87, the flag at bit 4 and two synchroniser stages. With these values the bench can reach the real neighbouring addresses 0x86 and 0x88. It can also watch the flag beside plain bits on both sides of it. The short synchroniser keeps every reset release within a few cycles.

The scenarios cover warm resets taken with the flag set and with it cleared. They also cover a write attempted while a warm reset is held, and a power-on reset that arrives during a warm reset with a clearing write on the bus.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  // Default geometry of the reset-cause register
  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_FLAG_BIT = 4;
  localparam int unsigned DEF_SYNC     = 2;

  // Per-bit reset domain selection
  typedef enum logic {
    DOM_WARM = 1'b0,
    DOM_COLD = 1'b1
  } rsc_dom_e;
endpackage

// File: rtl/rsc_rst_sync.sv
// Asynchronous assert, synchronous release of an active-low reset.
module rsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sr_q <= '0;
    else           sr_q <= sr_d;
  end

  assign rst_out_n = sr_q[STAGES-1];
endmodule

// File: rtl/rsc_reg_bits.sv
// Storage byte: one cold-domain clear-only flag, the rest warm-domain plain bits.
module rsc_reg_bits
  import rsc_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned FLAG_BIT = DEF_FLAG_BIT
) (
  input  logic              clk,
  input  logic              cold_ok,
  input  logic              warm_ok,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam rsc_dom_e DOM = (i == FLAG_BIT) ? DOM_COLD : DOM_WARM;
    logic bit_q;
    logic bit_d;

    if (DOM == DOM_COLD) begin : g_flag
      // Set by power-on reset; only a written 0 can change it, and only
      // while the warm domain is out of reset.
      always_comb begin
        bit_d = bit_q;
        if (wr_en && warm_ok && !wd[i]) bit_d = 1'b0;
      end
      always_ff @(posedge clk or negedge cold_ok) begin
        if (!cold_ok) bit_q <= 1'b1;
        else          bit_q <= bit_d;
      end
    end else begin : g_plain
      always_comb begin
        bit_d = bit_q;
        if (wr_en) bit_d = wd[i];
      end
      always_ff @(posedge clk or negedge warm_ok) begin
        if (!warm_ok) bit_q <= 1'b0;
        else          bit_q <= bit_d;
      end
    end

    assign q[i] = bit_q;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h87,
  parameter int unsigned FLAG_BIT    = DEF_FLAG_BIT,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              sfr_rsel
);
  logic              cold_ok;
  logic              warm_ok;
  logic              warm_src_n;
  logic              addr_hit;
  logic              wr_en;
  logic [DATA_W-1:0] reg_q;

  // Warm domain is held in reset by either raw source.
  assign warm_src_n = cold_rst_n & warm_rst_n;

  rsc_rst_sync #(.STAGES(SYNC_STAGES)) u_cold_sync (
    .clk       (clk),
    .rst_in_n  (cold_rst_n),
    .rst_out_n (cold_ok)
  );

  rsc_rst_sync #(.STAGES(SYNC_STAGES)) u_warm_sync (
    .clk       (clk),
    .rst_in_n  (warm_src_n),
    .rst_out_n (warm_ok)
  );

  assign addr_hit = (sfr_addr == REG_ADDR);
  assign wr_en    = sfr_wr & addr_hit;

  rsc_reg_bits #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_bits (
    .clk     (clk),
    .cold_ok (cold_ok),
    .warm_ok (warm_ok),
    .wr_en   (wr_en),
    .wd      (sfr_wdata),
    .q       (reg_q)
  );

  always_comb begin
    sfr_rdata = '0;
    if (addr_hit) sfr_rdata = reg_q;
  end
  assign sfr_rsel = addr_hit;
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h87,
  parameter int unsigned FLAG_BIT = 4
) (
  input logic              clk,
  input logic              cold_ok,
  input logic              warm_ok,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_wr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [DATA_W-1:0] reg_q
);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

  // High once at least one full cycle has passed since cold release.
  logic armed;
  always_ff @(posedge clk or negedge cold_ok) begin
    if (!cold_ok) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  AST_WARM_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!cold_ok)
    (armed && !warm_ok) |=> $stable(reg_q[FLAG_BIT])); // R2

  AST_WARM_CLEARS_PLAIN: assert property (@(posedge clk) disable iff (!cold_ok)
    !warm_ok |-> ((reg_q & ~FLAG_MASK) == '0)); // R2

  AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (!cold_ok)
    (armed && !$past(reg_q[FLAG_BIT])) |-> !reg_q[FLAG_BIT]); // R4

  AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!cold_ok)
    (armed && $past(sfr_wr && warm_ok && sfr_addr == REG_ADDR && !sfr_wdata[FLAG_BIT]))
    |-> !reg_q[FLAG_BIT]); // R3

  AST_FOREIGN_WRITE_HOLD: assert property (@(posedge clk) disable iff (!cold_ok)
    (armed && warm_ok && $past(warm_ok) && !$past(sfr_wr && sfr_addr == REG_ADDR))
    |-> $stable(reg_q)); // R7
endmodule

bind rst_cause_reg rst_cause_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk       (clk),
  .cold_ok   (cold_ok),
  .warm_ok   (warm_ok),
  .sfr_addr  (sfr_addr),
  .sfr_wr    (sfr_wr),
  .sfr_wdata (sfr_wdata),
  .reg_q     (reg_q)
);

// File: tb/rst_cause_reg_bench.sv
`timescale 1ns/1ps
module rst_cause_reg_bench;
  logic       clk = 1'b0;
  logic       cold_rst_n = 1'b0;
  logic       warm_rst_n = 1'b1;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       sfr_rsel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rst_cause_reg u_rst_cause_reg (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .sfr_rsel(sfr_rsel)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Combinational read, sampled mid-low-phase
  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic s);
    sfr_addr = a; sfr_wr = 1'b0;
    #2; d = sfr_rdata; s = sfr_rsel;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic t_cold_start;
    logic [7:0] d; logic s;
    @(negedge clk); cold_rst_n = 1'b0; cycles(3);
    cold_rst_n = 1'b1; cycles(4);
    rd(8'h87, d, s);
    chk("R1 cold start value", d, 8'h10);
    chk("R6 select at own address", {7'b0, s}, 8'h01);
  endtask

  task automatic t_plain_bits;
    logic [7:0] d; logic s;
    wr(8'h87, 8'h3B); rd(8'h87, d, s);
    chk("R5 store 0x3B with flag kept", d, 8'h3B);
    wr(8'h87, 8'hD5); rd(8'h87, d, s);
    chk("R5 store 0xD5", d, 8'hD5);
  endtask

  task automatic t_foreign;
    logic [7:0] d; logic s;
    wr(8'h86, 8'h00); wr(8'h88, 8'h00);
    rd(8'h86, d, s);
    chk("R6 rdata zero off address", d, 8'h00);
    chk("R6 select low off address", {7'b0, s}, 8'h00);
    rd(8'h87, d, s);
    chk("R7 neighbour writes ignored", d, 8'hD5);
  endtask

  task automatic t_warm(input logic [7:0] exp, input string tag);
    logic [7:0] d; logic s;
    @(negedge clk); warm_rst_n = 1'b0; cycles(2);
    warm_rst_n = 1'b1; cycles(4);
    rd(8'h87, d, s);
    chk(tag, d, exp);
  endtask

  task automatic t_clear;
    logic [7:0] d; logic s;
    wr(8'h87, 8'h00); rd(8'h87, d, s);
    chk("R3 zero write clears flag", d, 8'h00);
    wr(8'h87, 8'h10); rd(8'h87, d, s);
    chk("R4 one write does not set flag", d, 8'h00);
    wr(8'h87, 8'h50); rd(8'h87, d, s);
    chk("R4 flag stays clear, R5 bit6 stored", d, 8'h40);
  endtask

  task automatic t_write_in_warm;
    logic [7:0] d; logic s;
    wr(8'h87, 8'h1F); // set plain bits, flag remains 0
    @(negedge clk); warm_rst_n = 1'b0;
    sfr_addr = 8'h87; sfr_wdata = 8'hEE; sfr_wr = 1'b1; cycles(2);
    sfr_wr = 1'b0;
    rd(8'h87, d, s);
    chk("R2 R9 writes ignored during warm reset", d, 8'h00);
    warm_rst_n = 1'b1; cycles(1);
    sfr_addr = 8'h87; sfr_wdata = 8'h0F; sfr_wr = 1'b1; cycles(1);
    sfr_wr = 1'b0;
    rd(8'h87, d, s);
    chk("R9 write ignored before warm release syncs", d, 8'h00);
    cycles(3);
  endtask

  task automatic t_cold_priority;
    logic [7:0] d; logic s;
    wr(8'h87, 8'h00);
    @(negedge clk);
    warm_rst_n = 1'b0; cold_rst_n = 1'b0;
    sfr_addr = 8'h87; sfr_wdata = 8'h00; sfr_wr = 1'b1; cycles(3);
    sfr_wr = 1'b0; cold_rst_n = 1'b1; warm_rst_n = 1'b1; cycles(4);
    rd(8'h87, d, s);
    chk("R8 cold reset wins over warm and write", d, 8'h10);
  endtask

  initial begin
    fork
      begin
        cycles(2);
        t_cold_start();
        t_plain_bits();
        t_foreign();
        t_warm(8'h10, "R2 warm keeps set flag, clears rest");
        t_clear();
        t_warm(8'h00, "R2 warm keeps cleared flag");
        t_write_in_warm();
        t_cold_priority();
        done = 1'b1;
      end
      begin
        cycles(5000);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule